// File: doc/BRIEF.md
# Dual-Rate FIFO Write Port

This block is the write-side front end of a FIFO, together with the storage array that it fills. On each rising clock edge it samples an active-low write enable and an active-low write select. When both are low and the FIFO has room, the data word present at that edge is written. A static rate input selects one of two modes. In single-rate mode only the rising edge carries data. In double-rate mode a word is also taken from the data bus on the falling edge that follows an accepted rising edge. The falling-edge word is stored whatever the enable level is at that moment. It lands in the location directly after the rising-edge word.

The read side owns the read pointer and presents it as an input. The block compares that pointer with its own allocation pointer to detect a full FIFO. The block publishes a committed write pointer that only covers words already present in the array. When a double-rate pair finds just one free location, the rising word is kept, the falling word is dropped, and an overflow pulse reports the loss. A plain address port reads the array back.

Top module: `dfw_write_port`

## Requirements
- R1: Enable and select are sampled only at the rising clock edge. Their level at the falling edge has no effect.
- R2: With `ddr_mode`=0, at most one word is stored per rising edge: the `din` value at that edge, when `wen_n`=0, `wcs_n`=0 and `full`=0.
- R3: With `ddr_mode`=1, an accepted rising edge stores the rising-edge word at the current write location and the next falling-edge word at the following location.
- R4: The falling-edge word of an accepted double-rate cycle is stored even when `wen_n` is high at the falling edge.
- R5: A high `wcs_n` at a rising edge stores nothing at that edge or at the following falling edge, even when `wen_n` is low.
- R6: `full` is 1 exactly when allocated words minus `rd_ptr` equals DEPTH. While it is 1, no rising-edge word is stored and the array contents are unchanged.
- R7: In double-rate mode with exactly one free location, the rising word is stored, the falling word is discarded, and `wovf` is 1 for the single cycle after that rising edge.
- R8: A low `rst_n` at a rising edge clears `wr_ptr`, `full`, `wovf` and any pending falling word.
- R9: `wr_ptr` (PW bits, with a wrap bit above the address) counts a rising word after its own rising edge and a falling word after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; both edges are used in double-rate mode |
| rst_n | input | 1 | Synchronous active-low reset |
| ddr_mode | input | 1 | Static rate select: 0 single, 1 double |
| wen_n | input | 1 | Active-low write enable, sampled at the rising edge |
| wcs_n | input | 1 | Active-low write select, sampled at the rising edge |
| din | input | W | Write data |
| rd_ptr | input | PW | Read pointer from the read side, including the wrap bit |
| rd_addr | input | AW | Array read-back address |
| rd_data | output | W | Array word at `rd_addr` |
| wr_ptr | output | PW | Committed write pointer |
| full | output | 1 | FIFO has no free location |
| wovf | output | 1 | One-cycle pulse for a dropped falling-edge word |

## Verification
Two functions can meet at one rising edge. The first is the commit of the previous falling word. The second is either a new rising write or a refusal because the FIFO is full. The bench provokes the first case with back-to-back double-rate cycles. It provokes the second by filling the FIFO while a falling word is still pending, and then by freeing exactly one slot through `rd_ptr`. The results are judged by the committed pointer at each step, the single-cycle `wovf` pulse, and a final read-back of every array location against the expected interleaving.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  typedef enum logic {RATE_SDR = 1'b0, RATE_DDR = 1'b1} rate_e;

  // Words between two wrapping pointers of pw bits.
  function automatic logic [31:0] occupancy(input logic [31:0] wp, input logic [31:0] rp,
                                            input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  // Free locations left; saturates at zero.
  function automatic logic [31:0] free_slots(input logic [31:0] used, input int unsigned depth);
    return (used >= depth) ? 32'd0 : (depth - used);
  endfunction
endpackage

// File: rtl/dfw_edge_ctl.sv
module dfw_edge_ctl #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input  logic          rst_n,
  input  logic          ddr_mode,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [PW-1:0] alloc_ptr,
  input  logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          rise_wr,
  output logic          fall_arm,
  output logic          fall_drop
);
  import dfw_pkg::*;

  logic [31:0] used;
  logic [31:0] room;
  logic        sel;
  rate_e       rate;

  always_comb begin
    rate      = rate_e'(ddr_mode);
    used      = occupancy(32'(alloc_ptr), 32'(rd_ptr), PW);
    room      = free_slots(used, DEPTH);
    full      = (room == 32'd0);
    sel       = !wen_n && !wcs_n;
    rise_wr   = rst_n && sel && !full;
    fall_arm  = rise_wr && (rate == RATE_DDR) && (room >= 32'd2);
    fall_drop = rise_wr && (rate == RATE_DDR) && (room < 32'd2);
  end
endmodule

// File: rtl/dfw_fall_cap.sv
module dfw_fall_cap #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall_word
);
  always_ff @(negedge clk) begin
    fall_word <= din;
  end
endmodule

// File: rtl/dfw_ptr_unit.sv
module dfw_ptr_unit #(
  parameter int PW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_wr,
  input  logic          fall_arm,
  input  logic          fall_drop,
  output logic [PW-1:0] alloc_ptr,
  output logic [PW-1:0] commit_ptr,
  output logic          fall_pend,
  output logic [AW-1:0] fall_addr,
  output logic          ovf
);
  logic [PW-1:0] alloc_next;
  logic [PW-1:0] step_one;

  always_comb begin
    step_one   = alloc_ptr + PW'(1);
    alloc_next = alloc_ptr + PW'(rise_wr) + PW'(fall_arm);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ptr  <= '0;
      commit_ptr <= '0;
      fall_pend  <= 1'b0;
      fall_addr  <= '0;
      ovf        <= 1'b0;
    end else begin
      alloc_ptr  <= alloc_next;
      commit_ptr <= commit_ptr + PW'(fall_pend) + PW'(rise_wr);
      fall_pend  <= fall_arm;
      fall_addr  <= step_one[AW-1:0];
      ovf        <= fall_drop;
    end
  end
endmodule

// File: rtl/dfw_store.sv
module dfw_store #(
  parameter int W     = 10,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rise_we,
  input  logic [AW-1:0] rise_addr,
  input  logic [W-1:0]  rise_data,
  input  logic          fall_we,
  input  logic [AW-1:0] fall_addr,
  input  logic [W-1:0]  fall_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (fall_we) mem[fall_addr] <= fall_data;
    if (rise_we) mem[rise_addr] <= rise_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dfw_write_port.sv
module dfw_write_port #(
  parameter int W     = 10,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ddr_mode,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [W-1:0]  din,
  input  logic [PW-1:0] rd_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [PW-1:0] wr_ptr,
  output logic          full,
  output logic          wovf
);
  // Named internal events, visible to the bound checker.
  logic          rise_wr;
  logic          fall_arm;
  logic          fall_drop;
  logic          fall_pend;
  logic [AW-1:0] fall_addr;
  logic [PW-1:0] alloc_ptr;
  logic [W-1:0]  fall_word;

  dfw_edge_ctl #(.DEPTH(DEPTH), .PW(PW)) u_ctl (
    .rst_n(rst_n), .ddr_mode(ddr_mode), .wen_n(wen_n), .wcs_n(wcs_n),
    .alloc_ptr(alloc_ptr), .rd_ptr(rd_ptr), .full(full),
    .rise_wr(rise_wr), .fall_arm(fall_arm), .fall_drop(fall_drop)
  );

  dfw_fall_cap #(.W(W)) u_fcap (
    .clk(clk), .din(din), .fall_word(fall_word)
  );

  dfw_ptr_unit #(.PW(PW), .AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rise_wr(rise_wr), .fall_arm(fall_arm),
    .fall_drop(fall_drop), .alloc_ptr(alloc_ptr), .commit_ptr(wr_ptr),
    .fall_pend(fall_pend), .fall_addr(fall_addr), .ovf(wovf)
  );

  dfw_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk),
    .rise_we(rise_wr), .rise_addr(alloc_ptr[AW-1:0]), .rise_data(din),
    .fall_we(fall_pend && rst_n), .fall_addr(fall_addr), .fall_data(fall_word),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/dfw_write_port_chk.sv
module dfw_write_port_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ddr_mode,
  input logic          wcs_n,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_ptr,
  input logic          full,
  input logic          wovf,
  input logic          fall_pend
);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (wr_ptr == '0) && !wovf && !fall_pend);

  // R5
  select_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcs_n && !fall_pend |=> $stable(wr_ptr));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !fall_pend |=> $stable(wr_ptr));

  // R2
  sdr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_mode |-> !fall_pend);

  // R7
  ovf_only_ddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wovf |-> ddr_mode && !fall_pend);

  // R6
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= PW'(DEPTH));
endmodule

bind dfw_write_port dfw_write_port_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .wcs_n(wcs_n),
  .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .full(full), .wovf(wovf),
  .fall_pend(fall_pend)
);

// File: tb/dfw_write_port_test.sv
module dfw_write_port_test;
  localparam int W = 10;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ddr_mode = 1'b1;
  logic          wen_n = 1'b1;
  logic          wcs_n = 1'b1;
  logic [W-1:0]  din = '0;
  logic [PW-1:0] rd_ptr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [PW-1:0] wr_ptr;
  logic          full;
  logic          wovf;

  int n_run = 0;
  int n_fail = 0;

  dfw_write_port #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .wen_n(wen_n), .wcs_n(wcs_n),
    .din(din), .rd_ptr(rd_ptr), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .full(full), .wovf(wovf)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic          wen;
    logic          wcs;
    logic [PW-1:0] rdp;
    logic [W-1:0]  d0;
    logic [W-1:0]  d1;
    logic [PW-1:0] exp_wp;
    logic          exp_full;
    logic          exp_ovf;
  } vec_t;

  // Double-rate walk, DEPTH 8, no reads until the last two rows.
  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 4'd0, 10'h101, 10'h102, 4'd1, 1'b0, 1'b0}, // R3 R9 pair A
    '{1'b1, 1'b0, 4'd0, 10'h111, 10'h112, 4'd2, 1'b0, 1'b0}, // R1 enable high
    '{1'b0, 1'b1, 4'd0, 10'h111, 10'h112, 4'd2, 1'b0, 1'b0}, // R5 select high
    '{1'b0, 1'b0, 4'd0, 10'h121, 10'h122, 4'd3, 1'b0, 1'b0}, // R3
    '{1'b0, 1'b0, 4'd0, 10'h131, 10'h132, 4'd5, 1'b0, 1'b0}, // R9 commit + rise
    '{1'b0, 1'b0, 4'd0, 10'h141, 10'h142, 4'd7, 1'b1, 1'b0}, // R6 becomes full
    '{1'b0, 1'b0, 4'd0, 10'h151, 10'h152, 4'd8, 1'b1, 1'b0}, // R6 refused, pending commits
    '{1'b0, 1'b0, 4'd1, 10'h161, 10'h162, 4'd9, 1'b1, 1'b1}, // R7 one slot left
    '{1'b1, 1'b1, 4'd1, 10'h000, 10'h000, 4'd9, 1'b1, 1'b0}  // R7 pulse ends
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: controls and rise word before the rising edge, fall word after it,
  // with the enable pulled high for the falling edge (R1, R4).
  task automatic cyc(input logic wen, input logic wcs, input logic [PW-1:0] rdp,
                     input logic [W-1:0] d0, input logic [W-1:0] d1);
    wen_n = wen; wcs_n = wcs; rd_ptr = rdp; din = d0;
    @(posedge clk); #1;
    din = d1; wen_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; ddr_mode = mode;
    repeat (3) cyc(1'b1, 1'b1, '0, '0, '0);
    rst_n = 1'b1;
  endtask

  logic [W-1:0] exp_mem [DEPTH];

  initial begin
    #150000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    // Double-rate table walk
    do_reset(1'b1);
    check("R8 reset wr_ptr", 32'(wr_ptr), 0);
    check("R8 reset full", 32'(full), 0);
    check("R8 reset wovf", 32'(wovf), 0);
    for (int i = 0; i < 9; i++) begin
      cyc(VEC[i].wen, VEC[i].wcs, VEC[i].rdp, VEC[i].d0, VEC[i].d1);
      check($sformatf("R3/R6/R7/R9 row %0d wr_ptr", i), 32'(wr_ptr), 32'(VEC[i].exp_wp));
      check($sformatf("R6 row %0d full", i), 32'(full), 32'(VEC[i].exp_full));
      check($sformatf("R7 row %0d wovf", i), 32'(wovf), 32'(VEC[i].exp_ovf));
    end
    // R3 R4 R5 R7: rising words first, falling word next, blocked and dropped ones absent
    exp_mem = '{10'h161, 10'h102, 10'h121, 10'h122, 10'h131, 10'h132, 10'h141, 10'h142};
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a); #1;
      check($sformatf("R3/R4 mem[%0d]", a), 32'(rd_data), 32'(exp_mem[a]));
    end

    // Single-rate mode
    do_reset(1'b0);
    check("R8 reset after fill", 32'(wr_ptr), 0);
    check("R8 reset clears full", 32'(full), 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0, W'(10'h200 + i), W'(10'h300 + i));
    check("R2 one word per edge", 32'(wr_ptr), 3);
    for (int i = 0; i < 3; i++) begin
      rd_addr = AW'(i); #1;
      check($sformatf("R2 mem[%0d]", i), 32'(rd_data), 32'(10'h200 + i));
    end
    for (int i = 3; i < 8; i++) cyc(1'b0, 1'b0, '0, W'(10'h200 + i), W'(10'h300 + i));
    check("R6 full at depth", 32'(full), 1);
    cyc(1'b0, 1'b0, '0, 10'h3FF, 10'h3FE);
    check("R6 write refused", 32'(wr_ptr), 8);
    rd_addr = '0; #1;
    check("R6 contents kept", 32'(rd_data), 32'h200);
    check("R2 no overflow pulse", 32'(wovf), 0);

    // Reset while a falling word is pending
    do_reset(1'b1);
    cyc(1'b0, 1'b0, '0, 10'h0AA, 10'h0BB);
    check("R9 rise only counted", 32'(wr_ptr), 1);
    rst_n = 1'b0;
    cyc(1'b1, 1'b1, '0, '0, '0);
    rst_n = 1'b1;
    check("R8 reset clears pointer", 32'(wr_ptr), 0);
    cyc(1'b1, 1'b1, '0, '0, '0);
    check("R8 pending discarded", 32'(wr_ptr), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule